// File: doc/BRIEF.md
# PWM Buffered Timing Register Reload Controller

This block keeps the timing registers of a PWM channel in two copies. Software writes a shadow copy over a small register bus: the initial count, six compare values, six fractional values and a prescaler field. The counter logic sees a separate active copy. When the counter signals a reload and software has armed a load-enable bit, the whole shadow set moves into the active set in one clock edge, and the load-enable bit clears itself. This way a set of related values never reaches the waveform logic half-written.

A status word tracks whether this is working as intended. An update-pending bit shows that the shadow set holds data the active set does not have yet. A reload-error bit is raised when a reload arrives while data is pending but loading was not armed, so the pending data was skipped. A reload bit marks every reload. Capture bits record strobes from six capture channels. Compare bits record equality between the free-running counter and each active compare value. Every bit except update-pending is cleared by writing one to it.

Register map (4-bit address, 16-bit data): 0 control, with the prescaler in bits 2:0; 1 load-enable, in bit 0; 2 status; 3 initial count; 4+i compare value i, for i = 0..5; 10+i fractional value i. A read of a buffered register returns its shadow copy. The read data is combinational from the read address.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: A write to address 0, 3, 4..9 or 10..15 sets the update-pending status bit 14 at the next clock edge.
- R2: A reload while load-enable is 1 copies every shadow register into its active register at that edge, clears load-enable, and clears update-pending unless a buffered write lands in the same cycle. Such a write goes to the shadow copy only and keeps update-pending set.
- R3: A reload while load-enable is 0 leaves every active register and update-pending unchanged.
- R4: Reload-error, status bit 13, is set by a reload that arrives while load-enable is 0 and update-pending is 1. A reload with no pending data does not set it.
- R5: The reload status bit 12 is set by every reload, whatever the value of load-enable.
- R6: Capture strobe bit k of cap_i (k = 5..0, meaning channels A1, A0, B1, B0, X1, X0) sets status bit 6+k.
- R7: Compare status bit i (i = 0..5) is set on any cycle in which cnt_i equals active compare value i.
- R8: Writing the status address clears each of bits 13..0 written as 1. Bits written as 0 do not change. Update-pending (bit 14) cannot be cleared by a write.
- R9: When a hardware set and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R10: After reset, status reads 0, load-enable reads 0, and all shadow and active registers are 0.
- R11: Writing address 1 loads bit 0 of the data into load-enable, and a read of address 1 returns it in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data, combinational |
| reload_i | input | 1 | Reload event from the counter |
| cnt_i | input | 16 | Free-running counter value |
| cap_i | input | 6 | Capture strobes A1..X0 on bits 5..0 |
| act_init_o | output | 16 | Active initial count |
| act_val_o | output | 96 | Active compare values, value i in bits 16i+15:16i |
| act_frac_o | output | 96 | Active fractional values, same packing |
| act_prsc_o | output | 3 | Active prescaler |

## Verification
Two pairs of events can fall in the same cycle. The first pair is an armed reload and a buffered register write. The bench raises reload_i in the cycle of a compare-value write. It then expects the active value to take the old shadow contents, update-pending to stay set, and load-enable to clear. A second armed reload then has to deliver the new value. The second pair is a capture strobe and a write-one clear of the same status bit, driven on one clock edge. The bench reads the bit back as set, and then clears it with a write on its own.

// File: rtl/prc_pkg.sv
package prc_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 4;
    localparam int NCH     = 6;
    localparam int PRSC_W  = 3;
    localparam int FLAG_W  = 2 + 2 * NCH;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_LDEN  = 4'd1;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd2;
    localparam logic [ADDR_W-1:0] A_INIT  = 4'd3;
    localparam int                A_VAL0  = 4;
    localparam int                A_FRAC0 = A_VAL0 + NCH;

    localparam int ST_UPD = FLAG_W;

    typedef struct packed {
        logic            ctrl;
        logic            lden;
        logic            stat;
        logic            init;
        logic [NCH-1:0]  val;
        logic [NCH-1:0]  frac;
    } wr_dec_t;

    function automatic wr_dec_t decode_wr(input logic en, input logic [ADDR_W-1:0] a);
        wr_dec_t d;
        d      = '0;
        d.ctrl = en && (a == A_CTRL);
        d.lden = en && (a == A_LDEN);
        d.stat = en && (a == A_STAT);
        d.init = en && (a == A_INIT);
        for (int i = 0; i < NCH; i++) begin
            d.val[i]  = en && (int'(a) == A_VAL0 + i);
            d.frac[i] = en && (int'(a) == A_FRAC0 + i);
        end
        return d;
    endfunction

    function automatic logic any_buffered(input wr_dec_t d);
        return d.ctrl | d.init | (|d.val) | (|d.frac);
    endfunction

endpackage

// File: rtl/prc_shadow_bank.sv
module prc_shadow_bank
    import prc_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int PSW = PRSC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  wr_dec_t                 wd,
    input  logic [DW-1:0]           wr_data,
    input  logic                    reload,
    output logic [DW-1:0]           sh_init,
    output logic [NCH-1:0][DW-1:0]  sh_val,
    output logic [NCH-1:0][DW-1:0]  sh_frac,
    output logic [PSW-1:0]          sh_prsc,
    output logic [DW-1:0]           act_init,
    output logic [NCH-1:0][DW-1:0]  act_val,
    output logic [NCH-1:0][DW-1:0]  act_frac,
    output logic [PSW-1:0]          act_prsc,
    output logic                    upd,
    output logic                    ldok
);

    logic do_load;
    logic buf_wr;

    assign do_load = reload && ldok;
    assign buf_wr  = any_buffered(wd);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_init <= '0;
            sh_prsc <= '0;
        end else begin
            if (wd.init) sh_init <= wr_data;
            if (wd.ctrl) sh_prsc <= wr_data[PSW-1:0];
        end
    end

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_sh
            always_ff @(posedge clk) begin
                if (rst) begin
                    sh_val[i]   <= '0;
                    sh_frac[i]  <= '0;
                    act_val[i]  <= '0;
                    act_frac[i] <= '0;
                end else begin
                    if (wd.val[i])  sh_val[i]  <= wr_data;
                    if (wd.frac[i]) sh_frac[i] <= wr_data;
                    if (do_load) begin
                        act_val[i]  <= sh_val[i];
                        act_frac[i] <= sh_frac[i];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            act_init <= '0;
            act_prsc <= '0;
            upd      <= 1'b0;
            ldok     <= 1'b0;
        end else begin
            if (do_load) begin
                act_init <= sh_init;
                act_prsc <= sh_prsc;
            end
            if (buf_wr)       upd <= 1'b1;
            else if (do_load) upd <= 1'b0;
            if (wd.lden)      ldok <= wr_data[0];
            else if (do_load) ldok <= 1'b0;
        end
    end

endmodule

// File: rtl/prc_w1c_flags.sv
module prc_w1c_flags #(
    parameter int N = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)         q[i] <= 1'b0;
                else if (set[i]) q[i] <= 1'b1;
                else if (clr[i]) q[i] <= 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/prc_match.sv
module prc_match #(
    parameter int N  = 6,
    parameter int DW = 16
) (
    input  logic [DW-1:0]         cnt,
    input  logic [N-1:0][DW-1:0]  vals,
    output logic [N-1:0]          hit
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_cmp
            assign hit[i] = (cnt == vals[i]);
        end
    endgenerate

endmodule

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
    import prc_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W,
    parameter int PSW = PRSC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [DW-1:0]      rd_data,
    input  logic               reload_i,
    input  logic [DW-1:0]      cnt_i,
    input  logic [NCH-1:0]     cap_i,
    output logic [DW-1:0]      act_init_o,
    output logic [NCH*DW-1:0]  act_val_o,
    output logic [NCH*DW-1:0]  act_frac_o,
    output logic [PSW-1:0]     act_prsc_o
);

    localparam int PADW = DW - FLAG_W - 1;

    wr_dec_t                wd;
    logic [DW-1:0]          sh_init;
    logic [NCH-1:0][DW-1:0] sh_val;
    logic [NCH-1:0][DW-1:0] sh_frac;
    logic [PSW-1:0]         sh_prsc;
    logic [NCH-1:0][DW-1:0] act_val;
    logic [NCH-1:0][DW-1:0] act_frac;
    logic                   upd;
    logic                   ldok;
    logic [NCH-1:0]         hit;
    logic                   err_evt;
    logic [FLAG_W-1:0]      flg_set;
    logic [FLAG_W-1:0]      flg_clr;
    logic [FLAG_W-1:0]      flags;
    logic [DW-1:0]          status;

    assign wd = decode_wr(wr_en, wr_addr);

    prc_shadow_bank #(.DW(DW), .PSW(PSW)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wd       (wd),
        .wr_data  (wr_data),
        .reload   (reload_i),
        .sh_init  (sh_init),
        .sh_val   (sh_val),
        .sh_frac  (sh_frac),
        .sh_prsc  (sh_prsc),
        .act_init (act_init_o),
        .act_val  (act_val),
        .act_frac (act_frac),
        .act_prsc (act_prsc_o),
        .upd      (upd),
        .ldok     (ldok)
    );

    prc_match #(.N(NCH), .DW(DW)) u_match (
        .cnt  (cnt_i),
        .vals (act_val),
        .hit  (hit)
    );

    assign err_evt = reload_i && !ldok && upd;
    assign flg_set = {err_evt, reload_i, cap_i, hit};
    assign flg_clr = wd.stat ? wr_data[FLAG_W-1:0] : '0;

    prc_w1c_flags #(.N(FLAG_W)) u_flags (
        .clk (clk),
        .rst (rst),
        .set (flg_set),
        .clr (flg_clr),
        .q   (flags)
    );

    assign status     = {{PADW{1'b0}}, upd, flags};
    assign act_val_o  = act_val;
    assign act_frac_o = act_frac;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:  rd_data[PSW-1:0] = sh_prsc;
            A_LDEN:  rd_data[0]       = ldok;
            A_STAT:  rd_data          = status;
            A_INIT:  rd_data          = sh_init;
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (int'(rd_addr) == A_VAL0 + i)  rd_data = sh_val[i];
                    if (int'(rd_addr) == A_FRAC0 + i) rd_data = sh_frac[i];
                end
            end
        endcase
    end

endmodule

// File: rtl/prc_checker.sv
module prc_checker
    import prc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic [DW-1:0]     wr_data,
    input logic              reload_i,
    input logic [NCH-1:0]    cap_i,
    input logic              upd,
    input logic              ldok,
    input logic [FLAG_W-1:0] flags,
    input logic [DW-1:0]     sh_init,
    input logic [DW-1:0]     act_init_o
);

    logic buf_wr;
    logic lden_wr;
    logic stat_wr;
    assign buf_wr  = wr_en && (wr_addr == A_CTRL || int'(wr_addr) >= int'(A_INIT));
    assign lden_wr = wr_en && (wr_addr == A_LDEN);
    assign stat_wr = wr_en && (wr_addr == A_STAT);

    p_upd_set_r1: assert property (@(posedge clk) disable iff (rst)
        buf_wr |=> upd);

    p_copy_r2: assert property (@(posedge clk) disable iff (rst)
        reload_i && ldok |=> act_init_o == $past(sh_init));

    p_ldok_clr_r2: assert property (@(posedge clk) disable iff (rst)
        reload_i && ldok && !lden_wr |=> !ldok);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        reload_i && !ldok |=> $stable(act_init_o));

    p_err_set_r4: assert property (@(posedge clk) disable iff (rst)
        reload_i && !ldok && upd |=> flags[FLAG_W-1]);

    p_rld_set_r5: assert property (@(posedge clk) disable iff (rst)
        reload_i |=> flags[FLAG_W-2]);

    p_cap_set_r6: assert property (@(posedge clk) disable iff (rst)
        cap_i[NCH-1] |=> flags[2*NCH-1]);

    p_upd_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        upd && !(reload_i && ldok) |=> upd);

    p_zero_keep_r8: assert property (@(posedge clk) disable iff (rst)
        stat_wr && wr_data[FLAG_W-2] == 1'b0 && flags[FLAG_W-2] |=> flags[FLAG_W-2]);

endmodule

bind pwm_reload_ctrl prc_checker u_prc_checker (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .reload_i   (reload_i),
    .cap_i      (cap_i),
    .upd        (upd),
    .ldok       (ldok),
    .flags      (flags),
    .sh_init    (sh_init),
    .act_init_o (act_init_o)
);

// File: tb/pwm_reload_ctrl_bench.sv
module pwm_reload_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        reload_i = 1'b0;
    logic [15:0] cnt_i = 16'hFFFF;
    logic [5:0]  cap_i = '0;
    logic [15:0] act_init_o;
    logic [95:0] act_val_o;
    logic [95:0] act_frac_o;
    logic [2:0]  act_prsc_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pwm_reload_ctrl u_pwm_reload_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .reload_i(reload_i), .cnt_i(cnt_i),
        .cap_i(cap_i), .act_init_o(act_init_o), .act_val_o(act_val_o),
        .act_frac_o(act_frac_o), .act_prsc_o(act_prsc_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_reload();
        @(negedge clk);
        reload_i = 1'b1;
        @(negedge clk);
        reload_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(4'd2, d);  check("R10 status", d, 16'h0000);
        rd(4'd1, d);  check("R10 load-enable", d, 16'h0000);
        rd(4'd3, d);  check("R10 shadow init", d, 16'h0000);
        check("R10 active init", act_init_o, 16'h0000);
        check("R10 active vals", act_val_o[31:0], 32'h0);
    endtask

    task automatic t_update_pending();
        logic [15:0] d;
        bus_write(4'd3, 16'h1234);
        rd(4'd2, d);  check("R1 upd after init write", d[14], 1'b1);
        rd(4'd3, d);  check("R1 shadow readback", d, 16'h1234);
        check("R1 active untouched", act_init_o, 16'h0000);
        bus_write(4'd2, 16'h4000);
        rd(4'd2, d);  check("R8 upd not write-clearable", d[14], 1'b1);
    endtask

    task automatic t_reload_unarmed();
        logic [15:0] d;
        pulse_reload();
        rd(4'd2, d);
        check("R4 error on unarmed dirty reload", d[13], 1'b1);
        check("R5 reload flag", d[12], 1'b1);
        check("R3 upd kept", d[14], 1'b1);
        check("R3 active init kept", act_init_o, 16'h0000);
    endtask

    task automatic t_w1c();
        logic [15:0] d;
        bus_write(4'd2, 16'h0000);
        rd(4'd2, d);  check("R8 write zero no effect", d[13:12], 2'b11);
        bus_write(4'd2, 16'h2000);
        rd(4'd2, d);  check("R8 clear error only", d[13:12], 2'b01);
        bus_write(4'd2, 16'h1000);
        rd(4'd2, d);  check("R8 clear reload flag", d[13:0], 14'h0);
    endtask

    task automatic t_reload_armed();
        logic [15:0] d;
        bus_write(4'd6, 16'h0040);
        bus_write(4'd15, 16'h0007);
        bus_write(4'd0, 16'h0005);
        bus_write(4'd1, 16'h0001);
        rd(4'd1, d);  check("R11 load-enable reads 1", d, 16'h0001);
        pulse_reload();
        check("R2 init copied", act_init_o, 16'h1234);
        check("R2 val2 copied", act_val_o[47:32], 16'h0040);
        check("R2 frac5 copied", act_frac_o[95:80], 16'h0007);
        check("R2 prescaler copied", act_prsc_o, 3'd5);
        rd(4'd1, d);  check("R2 load-enable self-clears", d, 16'h0000);
        rd(4'd2, d);
        check("R2 upd cleared", d[14], 1'b0);
        check("R4 no error on armed reload", d[13], 1'b0);
        check("R5 reload flag armed", d[12], 1'b1);
        bus_write(4'd2, 16'h3FFF);
        pulse_reload();
        rd(4'd2, d);  check("R4 no error when clean", d[13:12], 2'b01);
        bus_write(4'd1, 16'h0001);
        bus_write(4'd1, 16'h0000);
        rd(4'd1, d);  check("R11 load-enable write 0", d, 16'h0000);
        bus_write(4'd2, 16'h3FFF);
    endtask

    task automatic t_compare();
        logic [15:0] d;
        @(negedge clk); cnt_i = 16'h0040;
        @(negedge clk); cnt_i = 16'hFFFF;
        rd(4'd2, d);  check("R7 compare bit 2 only", d[5:0], 6'b000100);
        bus_write(4'd2, 16'h0004);
        rd(4'd2, d);  check("R7 compare cleared", d[5:0], 6'b000000);
    endtask

    task automatic t_capture();
        logic [15:0] d;
        @(negedge clk); cap_i = 6'b100001;
        @(negedge clk); cap_i = 6'b000000;
        rd(4'd2, d);  check("R6 capture A1 and X0", d[11:6], 6'b100001);
        bus_write(4'd2, 16'h0FC0);
        rd(4'd2, d);  check("R6 capture cleared", d[11:6], 6'b000000);
    endtask

    task automatic t_set_wins();
        logic [15:0] d;
        @(negedge clk);
        cap_i = 6'b001000; wr_en = 1'b1; wr_addr = 4'd2; wr_data = 16'h0200;
        @(negedge clk);
        cap_i = 6'b000000; wr_en = 1'b0;
        rd(4'd2, d);  check("R9 set beats clear", d[9], 1'b1);
        bus_write(4'd2, 16'h0200);
        rd(4'd2, d);  check("R9 later clear works", d[9], 1'b0);
    endtask

    task automatic t_reload_with_write();
        logic [15:0] d;
        bus_write(4'd1, 16'h0001);
        @(negedge clk);
        reload_i = 1'b1; wr_en = 1'b1; wr_addr = 4'd4; wr_data = 16'h0099;
        @(negedge clk);
        reload_i = 1'b0; wr_en = 1'b0;
        check("R2 active val0 gets old shadow", act_val_o[15:0], 16'h0000);
        rd(4'd2, d);  check("R2 upd kept by same-cycle write", d[14], 1'b1);
        rd(4'd1, d);  check("R2 load-enable cleared", d, 16'h0000);
        bus_write(4'd1, 16'h0001);
        pulse_reload();
        check("R2 second reload delivers val0", act_val_o[15:0], 16'h0099);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_update_pending();
        t_reload_unarmed();
        t_w1c();
        t_reload_armed();
        t_compare();
        t_capture();
        t_set_wins();
        t_reload_with_write();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule